// File: doc/BRIEF.md
# Frame-Synchronised Serial Master

This block is the master side of a synchronous serial link that marks each 8-bit word with a one-clock frame-sync pulse instead of holding a chip select. Words are shifted out on `mosi` with the most significant bit first while `miso` is captured in the same order. The serial clock `sck` is made from the system clock by an even divider. It idles low, rises at the start of every bit slot and falls halfway through it. Received bits are sampled on the falling edge.

Transmit words enter through a one-entry buffer with a valid/ready handshake. `tx_ready` is high while the buffer is empty. A producer raises `tx_valid` and holds `tx_data` until it sees `tx_ready` in the same cycle. Received words leave through a one-entry buffer with `rx_valid` and `rx_ready`. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is seen. The serial side cannot be stalled, so a word that finishes while the buffer is still full is dropped and `ovr` is raised.

Whether the stream has gaps depends on when the next word arrives. If the next word is buffered by the time the last bit of the current word begins, the sync pulse is placed over that last bit and the next word follows without a gap. Otherwise the frame ends, and the next word gets its own header slot in which only the sync pulse is driven.

Top module: `tisync_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `sck`, `nss`, `mosi` and `busy` are all low.
- R2: A frame that starts from idle begins with one header slot: `nss` is high for exactly one SCK period, `sck` is high during the first half of that period, and `busy` rises at the same time.
- R3: Each bit slot lasts one SCK period: `sck` is high for H system clocks and then low for H system clocks, where H = `half_div`, and a value of 0 is treated as 1. `mosi` carries word bits 7 down to 0 and changes only where `sck` rises.
- R4: `miso` is sampled on each falling edge of `sck`, and the first sample becomes bit 7 of the received word.
- R5: If the transmit buffer holds a word when the last bit slot of the current word begins, `nss` is high for the whole of that last slot, and bit 7 of the next word follows at once with no header slot.
- R6: If no word is ready when the last bit slot begins, the frame ends. A word written later starts with its own header slot.
- R7: `tx_ready` is high exactly while the transmit buffer is empty. A word is accepted on a cycle with `tx_valid` and `tx_ready` both high. The buffer empties when its word moves into the shifter, which happens when a frame starts or at the end of the last bit of a continuous burst.
- R8: `mode` selects the direction: 0 or 3 is full-duplex, 1 is transmit-only, 2 is receive-only. In transmit-only mode the receive buffer is never written. In receive-only mode, `sck` runs word after word while `en` is high, `mosi` stays low, and the transmit buffer is neither needed nor emptied.
- R9: `rx_valid` rises and `rx_data` is loaded in the cycle after the final falling edge of a word. Both hold until a cycle with `rx_valid` and `rx_ready` high.
- R10: If a word completes while `rx_valid` is high and `rx_ready` is low, the held word is kept, the new word is discarded, and `ovr` is set. `ovr` stays set until `ovr_clr` is pulsed, and a new overrun in the same cycle takes priority over the clear.
- R11: `busy` is high from the first header slot until the falling edge of the last bit of the final word.
- R12: While `en` is low, no new frame starts. A receive-only stream finishes its current word and stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows frames to start |
| mode | input | 2 | Direction select (0/3 full-duplex, 1 transmit-only, 2 receive-only) |
| half_div | input | DIV_W | SCK half period in system clocks (0 acts as 1) |
| tx_data | input | WORD_W | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | Receive buffer holds a word |
| rx_ready | input | 1 | Consumer takes the received word |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr | output | 1 | Sticky overrun flag |
| sck | output | 1 | Serial clock |
| nss | output | 1 | Frame-sync pulse |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |

## Verification
A behavioural reference model in the bench is compared with every output on each clock. It is driven with back-to-back writes that must merge into one burst, and with writes spaced so that every word needs its own header. Counting SCK rises and sync pulses separates these two framings. The half-period input is run at 0, 2 and 3 so that off-by-one errors in the divider show up as slot-length mismatches. Receive-only streaming, transmit-only operation, a stalled consumer that forces an overrun, and a write made while the block is disabled each check a rule about what the block must keep or ignore.

// File: rtl/tisync_pkg.sv
package tisync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_BITS = 2'd2
  } tisync_state_e;

  localparam logic [1:0] MODE_FD = 2'd0;
  localparam logic [1:0] MODE_TX = 2'd1;
  localparam logic [1:0] MODE_RX = 2'd2;
endpackage

// File: rtl/tisync_clkgen.sv
module tisync_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (half_div == '0) ? '0 : half_div - 1'b1;
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load || tick)  cnt <= reload;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/tisync_txbuf.sv
module tisync_txbuf #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end
endmodule

// File: rtl/tisync_rxbuf.sv
module tisync_rxbuf #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              ovr_clr,
  output logic              ovr
);
  logic pop, clash;

  assign pop   = out_valid && out_ready;
  assign clash = load && out_valid && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      ovr       <= 1'b0;
    end else begin
      if (load && !clash) begin
        out_valid <= 1'b1;
        out_data  <= word;
      end else if (pop) begin
        out_valid <= 1'b0;
      end
      if (clash)        ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/tisync_framer.sv
module tisync_framer
  import tisync_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              tick,
  input  logic              txb_full,
  input  logic [WORD_W-1:0] txb_data,
  input  logic              miso,
  output logic              load,
  output logic              take,
  output logic              run,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              nss,
  output logic              mosi
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(WORD_W - 1);

  tisync_state_e    state;
  logic             ph;
  logic [CNT_W-1:0] bitn;
  logic             cont;
  logic [WORD_W-1:0] sh, rsh;
  logic             rx_only, avail, last_bit, end_hi, end_slot, chain;

  assign rx_only  = (mode == MODE_RX);
  assign avail    = en && (rx_only || txb_full);
  assign last_bit = (state == ST_BITS) && (bitn == '0);
  assign end_hi   = tick && !ph;
  assign end_slot = tick && ph;
  assign chain    = end_slot && last_bit && cont;

  assign load      = (state == ST_IDLE) && avail;
  assign take      = (load || chain) && !rx_only;
  assign run       = (state != ST_IDLE);
  assign word_done = end_hi && last_bit;
  assign rx_word   = {rsh[WORD_W-2:0], miso};

  assign sck  = run && !ph;
  assign nss  = (state == ST_HDR) || (last_bit && cont);
  assign mosi = (state == ST_BITS) && sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= 1'b0;
      bitn  <= '0;
      cont  <= 1'b0;
      sh    <= '0;
      rsh   <= '0;
    end else if (load) begin
      state <= ST_HDR;
      ph    <= 1'b0;
      cont  <= 1'b0;
      sh    <= rx_only ? '0 : txb_data;
    end else if (end_hi) begin
      if (state == ST_BITS) rsh <= rx_word;
      if (last_bit && !cont) begin
        state <= ST_IDLE;
        ph    <= 1'b0;
      end else begin
        ph <= 1'b1;
      end
    end else if (end_slot) begin
      ph <= 1'b0;
      if (state == ST_HDR) begin
        state <= ST_BITS;
        bitn  <= TOP_BIT;
      end else if (bitn != '0) begin
        bitn <= bitn - 1'b1;
        sh   <= sh << 1;
        if (bitn == CNT_W'(1)) cont <= avail;
      end else begin
        bitn <= TOP_BIT;
        cont <= 1'b0;
        sh   <= rx_only ? '0 : txb_data;
      end
    end
  end
endmodule

// File: rtl/tisync_master.sv
module tisync_master
  import tisync_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              ovr_clr,
  output logic              ovr,
  output logic              sck,
  output logic              nss,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  logic              tick, load, take, run, word_done, txb_full;
  logic [WORD_W-1:0] txb_data, rx_word;

  tisync_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .half_div(half_div), .tick(tick)
  );

  tisync_txbuf #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_data(tx_data), .in_valid(tx_valid),
    .in_ready(tx_ready), .take(take), .full(txb_full), .data(txb_data)
  );

  tisync_framer #(.WORD_W(WORD_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .tick(tick),
    .txb_full(txb_full), .txb_data(txb_data), .miso(miso),
    .load(load), .take(take), .run(run), .word_done(word_done),
    .rx_word(rx_word), .sck(sck), .nss(nss), .mosi(mosi)
  );

  tisync_rxbuf #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(word_done && (mode != MODE_TX)),
    .word(rx_word), .out_ready(rx_ready), .out_valid(rx_valid),
    .out_data(rx_data), .ovr_clr(ovr_clr), .ovr(ovr)
  );

  assign busy = run;
endmodule

// File: rtl/tisync_master_chk.sv
module tisync_master_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              ovr,
  input logic              ovr_clr,
  input logic              sck,
  input logic              nss,
  input logic              mosi,
  input logic              busy
);
  // R1
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !nss && !mosi));

  // R2
  header_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (nss && sck));

  // R3
  mosi_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mosi)) |-> $rose(sck));

  // R7
  tx_accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8
  rx_only_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !mosi);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
endmodule

bind tisync_master tisync_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .ovr(ovr), .ovr_clr(ovr_clr), .sck(sck), .nss(nss),
  .mosi(mosi), .busy(busy)
);

// File: tb/tisync_master_test.sv
`timescale 1ns/1ps
module tisync_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] half_div = 8'd2;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       ovr_clr = 1'b0;
  logic       ovr, sck, nss, mosi, busy;
  logic       miso = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tisync_master uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .half_div(half_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ovr_clr(ovr_clr), .ovr(ovr), .sck(sck), .nss(nss), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 header, 2 data bits
  int   m_phase, m_left, m_bit;
  bit   m_hi, m_cont, m_txf, m_rxv, m_ovr;
  bit [7:0] m_txd, m_out, m_in, m_rxd;

  function automatic int half_len();
    return (half_div == 0) ? 1 : int'(half_div);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_bit = 0; m_hi = 0; m_cont = 0;
      m_txf = 0; m_rxv = 0; m_ovr = 0; m_txd = 0; m_out = 0; m_in = 0; m_rxd = 0;
    end else begin
      bit rxonly, ready_next, finished, took, accept, popped, overrun;
      bit [7:0] got;
      rxonly = (mode == 2'd2);
      ready_next = en && (rxonly || m_txf);
      finished = 0; took = 0; got = {m_in[6:0], miso};
      accept = tx_valid && !m_txf;
      popped = m_rxv && rx_ready;
      if (m_phase == 0) begin
        if (ready_next) begin
          m_phase = 1; m_hi = 1; m_left = half_len(); m_cont = 0;
          m_out = rxonly ? 8'h00 : m_txd; took = !rxonly;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_left = half_len();
          if (m_hi) begin
            if (m_phase == 2) begin
              m_in = got;
              if (m_bit == 0) finished = 1;
            end
            if (finished && !m_cont) m_phase = 0;
            m_hi = 0;
          end else begin
            m_hi = 1;
            if (m_phase == 1) begin
              m_phase = 2; m_bit = 7;
            end else if (m_bit > 0) begin
              m_bit--; m_out = m_out << 1;
              if (m_bit == 0) m_cont = ready_next;
            end else begin
              m_bit = 7; m_cont = 0;
              m_out = rxonly ? 8'h00 : m_txd; took = !rxonly;
            end
          end
        end
      end
      if (took) m_txf = 0;
      else if (accept) begin m_txf = 1; m_txd = tx_data; end
      overrun = 0;
      if (finished && mode != 2'd1) begin
        if (m_rxv && !popped) overrun = 1;
        else begin m_rxv = 1; m_rxd = got; end
      end else if (popped) m_rxv = 0;
      if (overrun) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
    end
  end

  // lockstep comparison and edge counting, away from the active edge
  int sck_rises, nss_rises;
  bit p_sck, p_nss;
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sck, e_nss, e_mosi;
      e_sck  = (m_phase != 0) && m_hi;
      e_nss  = (m_phase == 1) || (m_phase == 2 && m_bit == 0 && m_cont);
      e_mosi = (m_phase == 2) && m_out[7];
      check(sck == e_sck, "R3 sck", sck, e_sck);
      check(nss == e_nss, "R2/R5 nss", nss, e_nss);
      check(mosi == e_mosi, "R3 mosi", mosi, e_mosi);
      check(busy == (m_phase != 0), "R11 busy", busy, m_phase != 0);
      check(tx_ready == !m_txf, "R7 tx_ready", tx_ready, !m_txf);
      check(rx_valid == m_rxv, "R9 rx_valid", rx_valid, m_rxv);
      check(!m_rxv || rx_data == m_rxd, "R4 rx_data", rx_data, m_rxd);
      check(ovr == m_ovr, "R10 ovr", ovr, m_ovr);
      if (sck && !p_sck) sck_rises++;
      if (nss && !p_nss) nss_rises++;
      p_sck = sck; p_nss = nss;
    end
    miso <= $urandom_range(0, 1);
  end

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!sck && !nss && !mosi && !busy, "R1 reset lines", {sck, nss, mosi, busy}, 0);
    check(tx_ready && !rx_valid && !ovr, "R1 reset buffers", {tx_ready, rx_valid, ovr}, 3'b100);

    // R5 continuous burst of three words, H=2
    en = 1'b1; mode = 2'd0; half_div = 8'd2;
    sck_rises = 0; nss_rises = 0;
    push(8'hA5); push(8'h3C); push(8'hF0);
    wait_idle();
    check(sck_rises == 25, "R5 burst sck rises", sck_rises, 25);
    check(nss_rises == 3, "R5 burst nss pulses", nss_rises, 3);

    // R6 gapped words, H=3
    half_div = 8'd3;
    sck_rises = 0; nss_rises = 0;
    push(8'h81); wait_idle();
    repeat (5) @(negedge clk);
    push(8'h7E); wait_idle();
    check(sck_rises == 18, "R6 gapped sck rises", sck_rises, 18);
    check(nss_rises == 2, "R6 gapped nss pulses", nss_rises, 2);

    // R3 half_div of 0 behaves as 1
    half_div = 8'd0;
    push(8'h5A); push(8'hC3); wait_idle();

    // R8 transmit-only leaves the receive buffer empty
    half_div = 8'd1; rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    mode = 2'd1;
    push(8'h12); wait_idle();
    repeat (2) @(negedge clk);
    check(!rx_valid, "R8 tx-only no rx word", rx_valid, 0);

    // R10 overrun: consumer stalled across two words
    mode = 2'd0; rx_ready = 1'b0;
    push(8'h11); push(8'h22); wait_idle();
    repeat (2) @(negedge clk);
    check(ovr == 1'b1, "R10 ovr set", ovr, 1);
    check(rx_valid && rx_data == m_rxd, "R10 first word kept", rx_data, m_rxd);
    repeat (4) @(negedge clk);
    check(ovr == 1'b1, "R10 ovr sticky", ovr, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    @(negedge clk);
    check(ovr == 1'b0, "R10 ovr cleared", ovr, 0);
    rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(!rx_valid, "R9 pop empties", rx_valid, 0);

    // R12 disabled block ignores a buffered word
    en = 1'b0;
    push(8'h99);
    repeat (40) @(negedge clk);
    check(!busy && !sck, "R12 no start while disabled", busy, 0);
    check(!tx_ready, "R12 word still held", tx_ready, 0);

    // R8 receive-only streams while enabled, tx buffer untouched
    mode = 2'd2; half_div = 8'd2; en = 1'b1;
    sck_rises = 0; nss_rises = 0;
    repeat (120) @(negedge clk);
    en = 1'b0;
    wait_idle();
    check(nss_rises >= 3, "R8 rx-only streaming", nss_rises, 3);
    check(sck_rises == 1 + 8 * nss_rises, "R8 rx-only one header", sck_rises, 1 + 8 * nss_rises);
    check(!tx_ready, "R8 rx-only keeps tx word", tx_ready, 0);

    // R7 back to full duplex sends the held word
    mode = 2'd0; en = 1'b1;
    wait_idle();
    repeat (2) @(negedge clk);
    check(tx_ready, "R7 held word consumed", tx_ready, 1);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule